// File: doc/BRIEF.md
# BCD Calendar Clock with Full-Match Alarm

This block keeps wall-clock time as packed BCD bytes: seconds, minutes, hours (24-hour count), day of month, month and a two-digit year. It runs on the system clock and advances on a one-cycle strobe that arrives at 32768 Hz. A prescaler turns these strobes into one update per second. The update carries through every field in one step. Month lengths and leap Februaries are handled in the same step.

Software reaches the block through a simple byte-wide register port on word-aligned offsets. It stops the counter, loads the time, sets the alarm fields and starts the counter again. It then reads the status for periodic events, for the alarm and for a busy window that warns when a counter update is near. One interrupt line combines the enabled event sources.

The alarm has one full set of time fields, and all six must match. No field can be left out of the comparison.

Top module: `bcd_calendar_rtc`

## Requirements
- R1: After reset, time reads 00:00:00 on day 01, month 01, year 00. The control, status, interrupt-enable and alarm registers read 0x00, and `irq` is low.
- R2: The time fields sit at offsets 0x00, 0x04, 0x08, 0x0C, 0x10 and 0x14 (seconds, minutes, hours, day, month, year). The alarm fields sit at 0x20 to 0x34 in the same order. A write stores the byte masked to the field width (seconds and minutes 0x7F, hours and day 0x3F, month 0x1F, year 0xFF), and a read returns that stored value.
- R3: While control bit 0 (run) is 0, no time field changes except by a register write.
- R4: Each one-second update increments seconds in BCD. Seconds and minutes wrap from 59 to 00 and carry. Hours wrap from 23 to 00 and carry into the day.
- R5: The day wraps to 01 after day 30 in April, June, September and November, after day 31 in the other long months, and after day 28 in February. In a year whose value is divisible by 4, February wraps after day 29 instead. Month wraps from 12 to 01 and year from 99 to 00.
- R6: Status bits 2, 3, 4 and 5 are set when the seconds, minutes, hours and day field (in that order) take a step in an update.
- R7: A read of the status register (offset 0x44) clears status bits 2 to 5 after returning them.
- R8: Status bit 6 is set one cycle after an update that leaves all six time fields equal to the six alarm fields. A mismatch in any one field, the year included, keeps it clear.
- R9: Writing 1 to status bit 6 clears the alarm flag. Writing 0 to that bit has no effect on it.
- R10: The interrupt-enable register is at offset 0x48. `irq` is high exactly when bit 3 is set together with the alarm flag, or bit 2 is set together with any of status bits 2 to 5.
- R11: With run set, status bit 0 (busy) is high for exactly one 32768 Hz tick period before every update, and status bit 1 mirrors the run bit.
- R12: Control register (offset 0x40) bit 3 holds the 12/24-hour selection and reads back as written. The other control bits apart from bit 0 read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle strobe at the 32768 Hz rate |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (clears periodic flags on status reads) |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from `bus_addr` |
| irq | output | 1 | Combined interrupt request |

## Verification
The time fields and status bits 2 to 5 change on the same clock edge where the last tick of a second is counted. The alarm flag follows one edge later. `irq` and the read data follow their registers with no added delay, and a status read clears the periodic flags on the edge that ends the read.

The bench lets the counter run for exactly 16k+8 clock cycles, with a tick every four cycles and four ticks per second. With that window, exactly k updates happen no matter where the run edge falls in the tick phase. The bench then stops the counter and reads every result from a frozen state, each read compared on the falling edge of its read cycle.

The busy window is measured over 48 consecutive read cycles, where exactly 12 must show the bit set.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  localparam int NFIELD = 6;
  localparam int F_SEC  = 0;
  localparam int F_MIN  = 1;
  localparam int F_HOUR = 2;
  localparam int F_DAY  = 3;
  localparam int F_MON  = 4;
  localparam int F_YEAR = 5;

  typedef logic [NFIELD-1:0][7:0] tfields_t;

  function automatic logic [7:0] field_mask(input int idx);
    case (idx)
      F_SEC, F_MIN:  return 8'h7F;
      F_HOUR, F_DAY: return 8'h3F;
      F_MON:         return 8'h1F;
      default:       return 8'hFF;
    endcase
  endfunction

  function automatic logic [7:0] field_first(input int idx);
    return (idx == F_DAY || idx == F_MON) ? 8'h01 : 8'h00;
  endfunction

  function automatic logic [6:0] bcd_to_bin(input logic [7:0] v);
    return (7'(v[7:4]) * 7'd10) + 7'(v[3:0]);
  endfunction

  function automatic logic leap_year(input logic [7:0] yr);
    logic [6:0] b;
    b = bcd_to_bin(yr);
    return (b[1:0] == 2'b00);
  endfunction

  function automatic logic [7:0] month_days(input logic [7:0] mon, input logic [7:0] yr);
    case (mon)
      8'h02:                      return leap_year(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  function automatic logic [7:0] field_last(input int idx, input logic [7:0] mon,
                                            input logic [7:0] yr);
    case (idx)
      F_SEC, F_MIN: return 8'h59;
      F_HOUR:       return 8'h23;
      F_DAY:        return month_days(mon, yr);
      F_MON:        return 8'h12;
      default:      return 8'h99;
    endcase
  endfunction

  // {wrap, next value}
  function automatic logic [8:0] bcd_step(input logic [7:0] v, input logic [7:0] last,
                                          input logic [7:0] first);
    if (v == last)          return {1'b1, first};
    else if (v[3:0] >= 4'd9) return {1'b0, v[7:4] + 4'd1, 4'd0};
    else                    return {1'b0, v + 8'd1};
  endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int TICKS_PER_SEC = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick,
  output logic busy,
  output logic step
);
  localparam int CW = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) cnt <= '0;
    else if (tick)      cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
  end

  assign busy = run && (cnt == LAST);
  assign step = busy && tick;

  // R11: an update is always preceded by at least one busy cycle
  assert_busy_leads_R11: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> $past(busy));

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                step,
  input  logic [NFIELD-1:0]   wr_field,
  input  logic [7:0]          wdata,
  output tfields_t            now,
  output logic [3:0]          events
);
  tfields_t       nxt;
  logic [NFIELD:0] carry;
  logic [8:0]     res;
  logic           unused_high_carry;

  always_comb begin
    carry[0] = step;
    res      = '0;
    for (int i = 0; i < NFIELD; i++) begin
      res        = bcd_step(now[i], field_last(i, now[F_MON], now[F_YEAR]), field_first(i));
      nxt[i]     = carry[i] ? res[7:0] : now[i];
      carry[i+1] = carry[i] & res[8];
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NFIELD; i++) begin
      if (!rst_n)           now[i] <= field_first(i);
      else if (wr_field[i]) now[i] <= wdata & field_mask(i);
      else                  now[i] <= nxt[i];
    end
  end

  // bit 0 seconds, 1 minutes, 2 hours, 3 day
  assign events = carry[3:0];
  assign unused_high_carry = ^carry[NFIELD:4];

  // R5: a day wrap always lands on day 01
  assert_day_wraps_to_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (carry[4] && !wr_field[F_DAY]) |=> (now[F_DAY] == 8'h01));

endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
  import rtc_pkg::*;
(
  input  tfields_t now,
  input  tfields_t target,
  output logic     match
);
  logic [NFIELD-1:0] eq;

  for (genvar g = 0; g < NFIELD; g++) begin : g_cmp
    assign eq[g] = (now[g] == target[g]);
  end

  assign match = &eq;

endmodule

// File: rtl/bcd_calendar_rtc.sv
module bcd_calendar_rtc
  import rtc_pkg::*;
#(
  parameter int ADDR_W        = 8,
  parameter int TICKS_PER_SEC = 32768
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_ALARM = ADDR_W'(8'h20);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(8'h40);
  localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(8'h44);
  localparam logic [ADDR_W-1:0] A_IEN   = ADDR_W'(8'h48);

  logic [NFIELD-1:0] wr_time, wr_alarm;
  tfields_t          time_now, alarm_q;
  logic              ctrl_run, ctrl_12h;
  logic              ie_timer, ie_alarm;
  logic [3:0]        ev_flags, new_ev;
  logic              alarm_flag, alarm_match, alarm_hit, step_d;
  logic              busy, step;
  logic              stat_rd, stat_wr;

  for (genvar g = 0; g < NFIELD; g++) begin : g_dec
    assign wr_time[g]  = bus_wr && (bus_addr == ADDR_W'(g * 4));
    assign wr_alarm[g] = bus_wr && (bus_addr == A_ALARM + ADDR_W'(g * 4));
  end

  assign stat_rd = bus_rd && (bus_addr == A_STAT);
  assign stat_wr = bus_wr && (bus_addr == A_STAT);

  rtc_prescaler #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(ctrl_run), .tick(tick), .busy(busy), .step(step)
  );

  rtc_calendar u_cal (
    .clk(clk), .rst_n(rst_n), .step(step), .wr_field(wr_time), .wdata(bus_wdata),
    .now(time_now), .events(new_ev)
  );

  rtc_alarm_match u_match (
    .now(time_now), .target(alarm_q), .match(alarm_match)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      alarm_q  <= '0;
      ctrl_run <= 1'b0;
      ctrl_12h <= 1'b0;
      ie_timer <= 1'b0;
      ie_alarm <= 1'b0;
      step_d   <= 1'b0;
    end else begin
      for (int i = 0; i < NFIELD; i++)
        if (wr_alarm[i]) alarm_q[i] <= bus_wdata & field_mask(i);
      if (bus_wr && bus_addr == A_CTRL) begin
        ctrl_run <= bus_wdata[0];
        ctrl_12h <= bus_wdata[3];
      end
      if (bus_wr && bus_addr == A_IEN) begin
        ie_timer <= bus_wdata[2];
        ie_alarm <= bus_wdata[3];
      end
      step_d <= step;
    end
  end

  assign alarm_hit = step_d && alarm_match;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ev_flags   <= '0;
      alarm_flag <= 1'b0;
    end else begin
      ev_flags   <= (stat_rd ? 4'b0 : ev_flags) | new_ev;
      alarm_flag <= alarm_hit || (alarm_flag && !(stat_wr && bus_wdata[6]));
    end
  end

  assign irq = (ie_alarm && alarm_flag) || (ie_timer && (|ev_flags));

  always_comb begin
    bus_rdata = 8'h00;
    for (int i = 0; i < NFIELD; i++) begin
      if (bus_addr == ADDR_W'(i * 4))           bus_rdata = time_now[i];
      if (bus_addr == A_ALARM + ADDR_W'(i * 4)) bus_rdata = alarm_q[i];
    end
    if (bus_addr == A_CTRL) bus_rdata = {4'b0, ctrl_12h, 2'b0, ctrl_run};
    if (bus_addr == A_STAT) bus_rdata = {1'b0, alarm_flag, ev_flags, ctrl_run, busy};
    if (bus_addr == A_IEN)  bus_rdata = {4'b0, ie_alarm, ie_timer, 2'b0};
  end

  // R3: stopped counter holds time unless software writes it
  assert_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_run && !(|wr_time)) |=> $stable(time_now));

  // R7: a status read with no new event leaves the periodic flags empty
  assert_clear_on_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !(|new_ev)) |=> (ev_flags == 4'b0));

  // R9: the alarm flag holds until a write of 1 to bit 6
  assert_alarm_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_flag && !alarm_hit && !(stat_wr && bus_wdata[6])) |=> alarm_flag);

  // R8: the alarm flag only rises after a full match
  assert_alarm_needs_match_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm_flag) |-> $past(alarm_match));

endmodule

// File: tb/bcd_calendar_rtc_test.sv
module bcd_calendar_rtc_test;
  localparam int CLK_PERIOD = 10;
  localparam int TPS        = 4;
  localparam int SEC_CYC    = 16;  // TPS ticks, one tick every 4 clocks

  localparam logic [7:0] A_SEC = 8'h00, A_MIN = 8'h04, A_HR = 8'h08, A_DAY = 8'h0C,
                         A_MON = 8'h10, A_YR = 8'h14, A_ALM = 8'h20,
                         A_CTRL = 8'h40, A_STAT = 8'h44, A_IEN = 8'h48;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick;
  logic       wr_en = 1'b0, rd_en = 1'b0, raw_mode = 1'b0;
  logic [7:0] addr = 8'h00, wdata = 8'h00;
  logic [7:0] rdata;
  logic       irq;
  logic [1:0] tdiv;
  int         vectors = 0;
  int         miscompares = 0;
  bit         done = 0;

  logic [7:0] addr_q[$], exp_q[$], mask_q[$];
  string      tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) tdiv <= 2'd0;
    else        tdiv <= tdiv + 2'd1;
  end
  assign tick = (tdiv == 2'd3);

  bcd_calendar_rtc #(.ADDR_W(8), .TICKS_PER_SEC(TPS)) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_wr(wr_en), .bus_rd(rd_en),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .irq(irq)
  );

  // scoreboard monitor
  always @(negedge clk) begin
    if (rd_en && !raw_mode) begin
      if (exp_q.size() == 0) begin
        miscompares++;
        $display("FAIL scoreboard underrun at addr %02h", addr);
      end else begin
        logic [7:0] a, e, m;
        string t;
        a = addr_q.pop_front(); e = exp_q.pop_front();
        m = mask_q.pop_front(); t = tag_q.pop_front();
        vectors++;
        if ((rdata & m) !== (e & m)) begin
          miscompares++;
          $display("FAIL %s addr %02h actual %02h expected %02h (mask %02h)", t, a, rdata, e, m);
        end
      end
    end
  end

  // all tasks are entered just after a rising edge
  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] e, input logic [7:0] m,
                    input string tag);
    addr_q.push_back(a); exp_q.push_back(e); mask_q.push_back(m); tag_q.push_back(tag);
    rd_en = 1'b1; addr = a;
    @(posedge clk); #1;
    rd_en = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string tag);
    @(negedge clk);
    vectors++;
    if (irq !== e) begin
      miscompares++;
      $display("FAIL %s irq actual %0b expected %0b", tag, irq, e);
    end
    @(posedge clk); #1;
  endtask

  task automatic load_time(input logic [7:0] s, input logic [7:0] mi, input logic [7:0] h,
                           input logic [7:0] d, input logic [7:0] mo, input logic [7:0] y);
    wr(A_SEC, s); wr(A_MIN, mi); wr(A_HR, h); wr(A_DAY, d); wr(A_MON, mo); wr(A_YR, y);
  endtask

  // run for 16k+8 cycles: exactly k updates, then stop
  task automatic run_secs(input int k);
    wr(A_CTRL, 8'h01);
    repeat (SEC_CYC * k + 7) @(posedge clk);
    #1;
    wr(A_CTRL, 8'h00);
  endtask

  task automatic roll_case(input logic [7:0] d, input logic [7:0] mo, input logic [7:0] y,
                           input logic [7:0] ed, input logic [7:0] emo, input logic [7:0] ey);
    load_time(8'h59, 8'h59, 8'h23, d, mo, y);
    run_secs(1);
    rd(A_HR, 8'h00, 8'hFF, "R5 hour");
    rd(A_DAY, ed, 8'hFF, "R5 day");
    rd(A_MON, emo, 8'hFF, "R5 month");
    rd(A_YR, ey, 8'hFF, "R5 year");
  endtask

  initial begin
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;

    // R1 reset state
    rd(A_SEC, 8'h00, 8'hFF, "R1 sec");
    rd(A_MIN, 8'h00, 8'hFF, "R1 min");
    rd(A_HR,  8'h00, 8'hFF, "R1 hour");
    rd(A_DAY, 8'h01, 8'hFF, "R1 day");
    rd(A_MON, 8'h01, 8'hFF, "R1 month");
    rd(A_YR,  8'h00, 8'hFF, "R1 year");
    rd(A_CTRL, 8'h00, 8'hFF, "R1 ctrl");
    rd(A_STAT, 8'h00, 8'hFF, "R1 status");
    rd(A_IEN, 8'h00, 8'hFF, "R1 ien");
    rd(A_ALM, 8'h00, 8'hFF, "R1 alarm sec");
    chk_irq(1'b0, "R1 irq");

    // R2 load and width masks
    wr(A_SEC, 8'h37); rd(A_SEC, 8'h37, 8'hFF, "R2 sec load");
    wr(A_SEC, 8'hFF); rd(A_SEC, 8'h7F, 8'hFF, "R2 sec mask");
    wr(A_HR, 8'hFF);  rd(A_HR, 8'h3F, 8'hFF, "R2 hour mask");
    wr(A_MON, 8'hFF); rd(A_MON, 8'h1F, 8'hFF, "R2 month mask");
    wr(A_ALM + 8'h0C, 8'hFF); rd(A_ALM + 8'h0C, 8'h3F, 8'hFF, "R2 alarm day mask");

    // R12 control bits
    wr(A_CTRL, 8'hFE); rd(A_CTRL, 8'h08, 8'hFF, "R12 ctrl readback");

    // R3 frozen while stopped
    load_time(8'h56, 8'h34, 8'h12, 8'h07, 8'h08, 8'h21);
    repeat (100) @(posedge clk);
    #1;
    rd(A_SEC, 8'h56, 8'hFF, "R3 sec frozen");
    rd(A_MIN, 8'h34, 8'hFF, "R3 min frozen");

    // R4 carry through a day, R6 flags, R7 clear, R10 timer irq
    wr(A_IEN, 8'h04);
    load_time(8'h59, 8'h59, 8'h23, 8'h15, 8'h06, 8'h24);
    run_secs(1);
    chk_irq(1'b1, "R10 timer irq on");
    rd(A_SEC, 8'h00, 8'hFF, "R4 sec");
    rd(A_MIN, 8'h00, 8'hFF, "R4 min");
    rd(A_HR,  8'h00, 8'hFF, "R4 hour");
    rd(A_DAY, 8'h16, 8'hFF, "R4 day");
    rd(A_STAT, 8'h3C, 8'hFF, "R6 all periodic flags");
    chk_irq(1'b0, "R10 timer irq after clear");
    rd(A_STAT, 8'h00, 8'hFF, "R7 flags cleared");
    wr(A_IEN, 8'h00);

    // R4 plain BCD digit carry
    load_time(8'h09, 8'h19, 8'h09, 8'h01, 8'h01, 8'h00);
    run_secs(1);
    rd(A_SEC, 8'h10, 8'hFF, "R4 digit carry");
    rd(A_STAT, 8'h04, 8'hFF, "R6 seconds flag only");

    // R5 month lengths and leap years
    roll_case(8'h30, 8'h04, 8'h24, 8'h01, 8'h05, 8'h24);
    roll_case(8'h30, 8'h09, 8'h24, 8'h01, 8'h10, 8'h24);
    roll_case(8'h31, 8'h01, 8'h00, 8'h01, 8'h02, 8'h00);
    roll_case(8'h28, 8'h02, 8'h23, 8'h01, 8'h03, 8'h23);
    roll_case(8'h28, 8'h02, 8'h24, 8'h29, 8'h02, 8'h24);
    roll_case(8'h29, 8'h02, 8'h24, 8'h01, 8'h03, 8'h24);
    roll_case(8'h28, 8'h02, 8'h00, 8'h29, 8'h02, 8'h00);
    roll_case(8'h31, 8'h12, 8'h99, 8'h01, 8'h01, 8'h00);
    rd(A_STAT, 8'h00, 8'h00, "R7 drain");

    // R8 alarm match, R9 clear, R10 alarm irq
    load_time(8'h40, 8'h30, 8'h12, 8'h10, 8'h03, 8'h24);
    wr(A_ALM + 8'h00, 8'h42); wr(A_ALM + 8'h04, 8'h30); wr(A_ALM + 8'h08, 8'h12);
    wr(A_ALM + 8'h0C, 8'h10); wr(A_ALM + 8'h10, 8'h03); wr(A_ALM + 8'h14, 8'h24);
    run_secs(3);
    rd(A_SEC, 8'h43, 8'hFF, "R4 three seconds");
    chk_irq(1'b0, "R10 alarm disabled");
    rd(A_STAT, 8'h44, 8'hFF, "R8 alarm flag set");
    wr(A_IEN, 8'h08);
    chk_irq(1'b1, "R10 alarm irq");
    wr(A_STAT, 8'h3F);
    rd(A_STAT, 8'h40, 8'hFF, "R9 write zero keeps flag");
    chk_irq(1'b1, "R9 irq still high");
    wr(A_STAT, 8'h40);
    rd(A_STAT, 8'h00, 8'hFF, "R9 write one clears");
    chk_irq(1'b0, "R10 irq low after clear");

    // R8 year mismatch never fires
    load_time(8'h40, 8'h30, 8'h12, 8'h10, 8'h03, 8'h24);
    wr(A_ALM + 8'h14, 8'h25);
    run_secs(3);
    rd(A_STAT, 8'h04, 8'hFF, "R8 year mismatch");
    chk_irq(1'b0, "R8 no alarm irq");
    wr(A_IEN, 8'h00);

    // R11 busy window and run bit
    begin
      int busy_cnt = 0;
      int run_low = 0;
      wr(A_CTRL, 8'h01);
      raw_mode = 1'b1; rd_en = 1'b1; addr = A_STAT;
      for (int i = 0; i < 48; i++) begin
        @(negedge clk);
        if (rdata[0]) busy_cnt++;
        if (!rdata[1]) run_low++;
      end
      @(posedge clk); #1;
      rd_en = 1'b0; raw_mode = 1'b0;
      wr(A_CTRL, 8'h00);
      vectors++;
      if (busy_cnt != 12) begin
        miscompares++;
        $display("FAIL R11 busy cycles actual %0d expected 12", busy_cnt);
      end
      vectors++;
      if (run_low != 0) begin
        miscompares++;
        $display("FAIL R11 run bit low cycles actual %0d expected 0", run_low);
      end
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule